// File: doc/BRIEF.md
# Transport-Stream System Time Clock with Timestamp Converter

This block keeps the system time of a transport-stream encoder or decoder. It advances on a 27 MHz clock enable. A 9-bit fine field counts through 300 states. Each time the fine field rolls over, a 33-bit coarse field steps by one, so the coarse field runs at 90 kHz. The coarse field wraps to zero after its all-ones value.

Software or a neighbouring block can preset both fields through a load port. A snapshot request latches the coarse and fine fields together in one cycle, so a rollover can never split the pair. A one-cycle pulse marks the wrap of the coarse field.

A sequential converter takes the captured coarse value and turns it into hours, minutes, seconds and milliseconds. It works by repeated subtraction of fixed tick counts. Milliseconds are truncated, not rounded.

Top module: `pcr_clock_top`

## Requirements
- R1: After synchronous reset, both fields are zero and `snap_valid`, `wrap_pulse`, `conv_busy` and `conv_done` are low.
- R2: With `tick_en` high and no load, the fine field steps by one per cycle from 0 up to 299 and then returns to 0. With `tick_en` low it holds.
- R3: The coarse field increments by one exactly on the ticks where the fine field goes from 299 to 0.
- R4: The coarse field wraps from 0x1FFFFFFFF to 0. `wrap_pulse` is high for exactly the one cycle after that wrap edge and is low at all other times.
- R5: `load_en` writes `load_base` and `load_ext` into the fields and wins over a tick in the same cycle. A fine value of 300 or more is stored as 299. A load never raises `wrap_pulse`.
- R6: `snap_req` latches the pair that the fields hold in that cycle. `snap_base` and `snap_ext` show the pair in the following cycle, with a one-cycle `snap_valid`.
- R7: `conv_start` while idle converts the current `snap_base`. `conv_busy` stays high until a one-cycle `conv_done`. The outputs then hold floor(v/324000000) hours, the minutes and seconds that remain, and floor(rest/90) milliseconds. A `conv_start`, and any new snapshot, taken while busy do not alter the result.
- R8: A coarse value of 0 converts to 00:00:00.000, and 0x1FFFFFFFF converts to 26:30:43.717.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 27 MHz count enable |
| load_en | input | 1 | Preset both fields |
| load_base | input | 33 | Coarse preset value |
| load_ext | input | 9 | Fine preset value (clamped to 299) |
| snap_req | input | 1 | Capture the current pair |
| conv_start | input | 1 | Start converting `snap_base` |
| snap_valid | output | 1 | Pulse one cycle after a capture |
| snap_base | output | 33 | Captured coarse field |
| snap_ext | output | 9 | Captured fine field |
| wrap_pulse | output | 1 | Coarse field wrapped to zero |
| conv_busy | output | 1 | Converter running |
| conv_done | output | 1 | Conversion finished, one cycle |
| ts_hours | output | 5 | Converted hours |
| ts_minutes | output | 6 | Converted minutes |
| ts_seconds | output | 6 | Converted seconds |
| ts_millis | output | 10 | Converted milliseconds, truncated |

## Verification
The coarse wrap is the hardest state to reach. Counting to it from reset would take about 2.6e12 ticks. The bench therefore loads the coarse field with its all-ones value and the fine field with 297, then ticks through the double rollover.

The same preset method places captures one cycle before and one cycle after the fine rollover, which tests that the captured pair stays consistent. For the converter, a second capture is taken while it is busy, so that the bench can show the result is unaffected.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    typedef struct packed {
        logic [4:0] hours;
        logic [5:0] minutes;
        logic [5:0] seconds;
        logic [9:0] millis;
    } hms_t;

    typedef enum logic [2:0] {
        CV_IDLE,
        CV_HRS,
        CV_MIN,
        CV_SEC,
        CV_MS
    } conv_state_t;

    localparam int DEF_EXT_MOD  = 300;
    localparam int DEF_BASE_W   = 33;
    localparam int DEF_TICK_HZ  = 90000;

endpackage

// File: rtl/pcr_ext_counter.sv
module pcr_ext_counter #(
    parameter int EXT_MOD = 300,
    parameter int EXT_W   = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load_en,
    input  logic [EXT_W-1:0] load_val,
    output logic [EXT_W-1:0] ext_q,
    output logic             roll
);
    localparam logic [EXT_W-1:0] LAST = EXT_W'(EXT_MOD - 1);

    logic [EXT_W-1:0] load_clamped;

    always_comb begin
        load_clamped = (load_val > LAST) ? LAST : load_val;
        roll         = tick_en && !load_en && (ext_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= '0;
        end else if (load_en) begin
            ext_q <= load_clamped;
        end else if (tick_en) begin
            ext_q <= (ext_q == LAST) ? '0 : ext_q + 1'b1;
        end
    end
endmodule

// File: rtl/pcr_base_counter.sv
module pcr_base_counter #(
    parameter int BASE_W = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              load_en,
    input  logic [BASE_W-1:0] load_val,
    output logic [BASE_W-1:0] base_q,
    output logic              wrap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            wrap   <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (load_en) begin
                base_q <= load_val;
            end else if (inc) begin
                base_q <= base_q + 1'b1;
                wrap   <= &base_q;
            end
        end
    end
endmodule

// File: rtl/pcr_snapshot.sv
module pcr_snapshot #(
    parameter int BASE_W = 33,
    parameter int EXT_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [BASE_W-1:0] base_in,
    input  logic [EXT_W-1:0]  ext_in,
    output logic [BASE_W-1:0] base_out,
    output logic [EXT_W-1:0]  ext_out,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_out <= '0;
            ext_out  <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= req;
            if (req) begin
                base_out <= base_in;
                ext_out  <= ext_in;
            end
        end
    end
endmodule

// File: rtl/pcr_time_conv.sv
module pcr_time_conv
    import pcr_pkg::*;
#(
    parameter int BASE_W  = 33,
    parameter int TICK_HZ = 90000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BASE_W-1:0] value,
    output logic              busy,
    output logic              done,
    output hms_t              stamp
);
    localparam logic [BASE_W-1:0] U_HR  = BASE_W'(64'(TICK_HZ) * 64'd3600);
    localparam logic [BASE_W-1:0] U_MIN = BASE_W'(64'(TICK_HZ) * 64'd60);
    localparam logic [BASE_W-1:0] U_SEC = BASE_W'(TICK_HZ);
    localparam logic [BASE_W-1:0] U_MS  = BASE_W'(TICK_HZ / 1000);

    conv_state_t       state;
    logic [BASE_W-1:0] rem;

    assign busy = (state != CV_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CV_IDLE;
            rem   <= '0;
            stamp <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                CV_IDLE: if (start) begin
                    rem   <= value;
                    stamp <= '0;
                    state <= CV_HRS;
                end
                CV_HRS: if (rem >= U_HR) begin
                    rem         <= rem - U_HR;
                    stamp.hours <= stamp.hours + 1'b1;
                end else begin
                    state <= CV_MIN;
                end
                CV_MIN: if (rem >= U_MIN) begin
                    rem           <= rem - U_MIN;
                    stamp.minutes <= stamp.minutes + 1'b1;
                end else begin
                    state <= CV_SEC;
                end
                CV_SEC: if (rem >= U_SEC) begin
                    rem           <= rem - U_SEC;
                    stamp.seconds <= stamp.seconds + 1'b1;
                end else begin
                    state <= CV_MS;
                end
                CV_MS: if (rem >= U_MS) begin
                    rem          <= rem - U_MS;
                    stamp.millis <= stamp.millis + 1'b1;
                end else begin
                    state <= CV_IDLE;
                    done  <= 1'b1;
                end
                default: state <= CV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pcr_clock_top.sv
module pcr_clock_top
    import pcr_pkg::*;
#(
    parameter int EXT_MOD    = DEF_EXT_MOD,
    parameter int BASE_W     = DEF_BASE_W,
    parameter int TICK_HZ    = DEF_TICK_HZ,
    localparam int EXT_W     = $clog2(EXT_MOD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              load_en,
    input  logic [BASE_W-1:0] load_base,
    input  logic [EXT_W-1:0]  load_ext,
    input  logic              snap_req,
    input  logic              conv_start,
    output logic              snap_valid,
    output logic [BASE_W-1:0] snap_base,
    output logic [EXT_W-1:0]  snap_ext,
    output logic              wrap_pulse,
    output logic              conv_busy,
    output logic              conv_done,
    output logic [4:0]        ts_hours,
    output logic [5:0]        ts_minutes,
    output logic [5:0]        ts_seconds,
    output logic [9:0]        ts_millis
);
    logic [EXT_W-1:0]  ext_q;
    logic [BASE_W-1:0] base_q;
    logic              ext_roll;
    hms_t              stamp;

    pcr_ext_counter #(.EXT_MOD(EXT_MOD), .EXT_W(EXT_W)) u_ext (
        .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
        .load_val(load_ext), .ext_q(ext_q), .roll(ext_roll)
    );

    pcr_base_counter #(.BASE_W(BASE_W)) u_base (
        .clk(clk), .rst(rst), .inc(ext_roll), .load_en(load_en),
        .load_val(load_base), .base_q(base_q), .wrap(wrap_pulse)
    );

    pcr_snapshot #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_snap (
        .clk(clk), .rst(rst), .req(snap_req), .base_in(base_q),
        .ext_in(ext_q), .base_out(snap_base), .ext_out(snap_ext),
        .valid(snap_valid)
    );

    pcr_time_conv #(.BASE_W(BASE_W), .TICK_HZ(TICK_HZ)) u_conv (
        .clk(clk), .rst(rst), .start(conv_start), .value(snap_base),
        .busy(conv_busy), .done(conv_done), .stamp(stamp)
    );

    assign ts_hours   = stamp.hours;
    assign ts_minutes = stamp.minutes;
    assign ts_seconds = stamp.seconds;
    assign ts_millis  = stamp.millis;
endmodule

// File: rtl/pcr_clock_chk.sv
module pcr_clock_chk #(
    parameter int EXT_MOD = 300,
    parameter int BASE_W  = 33,
    parameter int EXT_W   = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              load_en,
    input logic [BASE_W-1:0] load_base,
    input logic              snap_req,
    input logic              snap_valid,
    input logic              wrap_pulse,
    input logic              conv_done,
    input logic [EXT_W-1:0]  ext_q,
    input logic [BASE_W-1:0] base_q
);
    p_ext_range_r2: assert property (@(posedge clk) disable iff (rst)
        ext_q < EXT_W'(EXT_MOD));

    p_ext_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !load_en && ext_q != EXT_W'(EXT_MOD - 1))
        |=> ext_q == EXT_W'($past(ext_q) + 1'b1));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !load_en) |=> ($stable(ext_q) && $stable(base_q)));

    p_base_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !load_en && ext_q == EXT_W'(EXT_MOD - 1))
        |=> (base_q == BASE_W'($past(base_q) + 1'b1) && ext_q == '0));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> (base_q == '0 && ext_q == '0));

    p_wrap_single_r4: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> !wrap_pulse);

    p_load_win_r5: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (base_q == $past(load_base) && !wrap_pulse));

    p_snap_valid_r6: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> snap_valid);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !conv_done);
endmodule

bind pcr_clock_top pcr_clock_chk #(
    .EXT_MOD(EXT_MOD), .BASE_W(BASE_W), .EXT_W(EXT_W)
) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
    .load_base(load_base), .snap_req(snap_req), .snap_valid(snap_valid),
    .wrap_pulse(wrap_pulse), .conv_done(conv_done),
    .ext_q(ext_q), .base_q(base_q)
);

// File: tb/pcr_clock_top_tb.sv
module pcr_clock_top_tb;
    localparam logic [32:0] MAXB = 33'h1FFFFFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 0, load_en = 0, snap_req = 0, conv_start = 0;
    logic [32:0] load_base = '0;
    logic [8:0]  load_ext = '0;
    logic        snap_valid, wrap_pulse, conv_busy, conv_done;
    logic [32:0] snap_base;
    logic [8:0]  snap_ext;
    logic [4:0]  ts_hours;
    logic [5:0]  ts_minutes, ts_seconds;
    logic [9:0]  ts_millis;

    int total = 0;
    int bad = 0;
    logic [32:0] m_base = '0;
    logic [8:0]  m_ext = '0;

    always #10 clk = ~clk;

    pcr_clock_top u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
        .load_base(load_base), .load_ext(load_ext), .snap_req(snap_req),
        .conv_start(conv_start), .snap_valid(snap_valid), .snap_base(snap_base),
        .snap_ext(snap_ext), .wrap_pulse(wrap_pulse), .conv_busy(conv_busy),
        .conv_done(conv_done), .ts_hours(ts_hours), .ts_minutes(ts_minutes),
        .ts_seconds(ts_seconds), .ts_millis(ts_millis)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive after negedge, model the edge, compare at next negedge
    task automatic cyc(input logic t, input logic l, input logic [32:0] lb,
                       input logic [8:0] le, input logic s);
        logic [32:0] sb;
        logic [8:0]  se;
        logic        we;
        tick_en = t; load_en = l; load_base = lb; load_ext = le; snap_req = s;
        sb = m_base; se = m_ext;
        we = t && !l && m_ext == 9'd299 && m_base == MAXB;
        if (l) begin
            m_base = lb;
            m_ext  = (le > 9'd299) ? 9'd299 : le;
        end else if (t) begin
            if (m_ext == 9'd299) begin
                m_ext  = 0;
                m_base = m_base + 1'b1;
            end else begin
                m_ext = m_ext + 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        tick_en = 0; load_en = 0; snap_req = 0; conv_start = 0;
        check("R4 wrap_pulse", wrap_pulse, we);
        if (s) begin
            check("R6 snap_valid", snap_valid, 1);
            check("R2/R3 snap_ext", snap_ext, se);
            check("R3 snap_base", snap_base, sb);
        end else begin
            check("R6 snap_valid idle", snap_valid, 0);
        end
    endtask

    task automatic convert(input logic [32:0] v);
        longint r, eh, em, es, ems;
        int n;
        bit seen;
        cyc(0, 1, v, 9'd5, 0);
        cyc(0, 0, '0, '0, 1);
        conv_start = 1;
        cyc(0, 0, '0, '0, 0);
        check("R7 busy", conv_busy, 1);
        // disturb: new snapshot and a second start while busy
        cyc(0, 1, 33'd12345678, 9'd0, 0);
        cyc(0, 0, '0, '0, 1);
        conv_start = 1;
        cyc(0, 0, '0, '0, 0);
        seen = 0;
        for (n = 0; n < 3000 && !seen; n++) begin
            if (conv_done) seen = 1;
            else cyc(1, 0, '0, '0, 0);
        end
        check("R7 done reached", seen, 1);
        r = longint'(v);
        eh = r / 324000000; r = r % 324000000;
        em = r / 5400000;   r = r % 5400000;
        es = r / 90000;     r = r % 90000;
        ems = r / 90;
        check("R7 hours", ts_hours, eh);
        check("R7 minutes", ts_minutes, em);
        check("R7 seconds", ts_seconds, es);
        check("R7 millis", ts_millis, ems);
        cyc(0, 0, '0, '0, 0);
        check("R7 done one cycle", conv_done, 0);
        check("R7 idle after", conv_busy, 0);
        // let any restart (there must be none) show up
        cyc(0, 0, '0, '0, 0);
        check("R7 no restart", conv_busy, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 snap_valid", snap_valid, 0);
        check("R1 wrap", wrap_pulse, 0);
        check("R1 busy", conv_busy, 0);
        check("R1 done", conv_done, 0);
        cyc(0, 0, '0, '0, 1);
        check("R1 ext zero", snap_ext, 0);
        check("R1 base zero", snap_base, 0);

        // R2/R3 full fine sweep with gaps in the enable
        cyc(0, 1, 33'd5, 9'd0, 0);
        for (int i = 0; i < 1000; i++) cyc(i % 3 != 0, 0, '0, '0, 1);

        // R5 clamp and load priority over tick
        cyc(1, 1, 33'd77, 9'd400, 1);
        cyc(0, 0, '0, '0, 1);
        check("R5 clamp", snap_ext, 299);
        check("R5 load base", snap_base, 77);
        cyc(1, 0, '0, '0, 1);
        cyc(0, 0, '0, '0, 1);
        check("R3 roll after clamp", snap_base, 78);

        // R4 wrap across double rollover, with snapshots around it
        cyc(0, 1, MAXB, 9'd297, 0);
        for (int i = 0; i < 8; i++) cyc(1, 0, '0, '0, 1);
        check("R4 base after wrap", m_base, 0);
        // R5 load of max with tick: no wrap
        cyc(1, 1, MAXB, 9'd299, 0);
        cyc(1, 1, 33'd0, 9'd0, 0);
        cyc(0, 0, '0, '0, 1);

        // R7/R8 conversions
        convert(33'd0);
        convert(MAXB);
        convert(33'd329490539);
        convert(33'd89);
        convert(33'd323999999);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule